// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the part of an 8-bit processor core that decides, at each instruction boundary, whether the core goes on fetching or enters an interrupt. The core raises a one-cycle boundary strobe when an instruction completes. The sequencer then looks at the latched non-maskable request, the level of the maskable request, the enable flags and the interrupt mode. When it accepts an interrupt, it runs the whole entry sequence on its own. That sequence is an acknowledge period, two stack pushes of the return address, an optional two-byte vector fetch and the load of the new program counter. One clock equals one T-state.

The block holds the architectural state that interrupt entry touches: program counter, stack pointer, vector-base register, refresh counter, interrupt mode, both enable flags and the halted flag. The core updates this state through simple write ports while the sequencer is idle. A free-running counter adds up the T-states spent in entry sequences. A one-cycle done strobe hands control back to fetch.

Top module: `intr_entry_seq`

## Requirements
- R1: After synchronous reset, pc, sp, i_reg, r_reg, im, iff1, iff2, halted, nmi_pend, ack_err, busy and tstates are all zero.
- R2: A rising edge on nmi (low in one cycle, high in the next) sets nmi_pend. Holding nmi high produces no further edge. nmi_pend clears on the cycle the non-maskable entry starts.
- R3: Non-maskable entry lasts 11 busy cycles: a 5-cycle acknowledge, then two 3-cycle writes. It writes the return pc high byte to sp-1 and the low byte to sp-2, leaves sp two lower and loads pc with 0x0066. It clears iff1 and leaves iff2 unchanged.
- R4: When nmi_pend and int_req are both present at a boundary, the non-maskable entry is the one taken.
- R5: int_req is a level that is sampled only on a cycle with boundary high while the block is idle. It is honoured only when iff1 is 1. A request that goes away before the boundary starts no entry.
- R6: A maskable entry clears both iff1 and iff2.
- R7: If halted is 1 when either entry starts, halted clears and the pushed return address is pc+1.
- R8: In mode 1 the entry lasts 13 cycles (7-cycle acknowledge plus two writes) and loads pc with 0x0038.
- R9: In mode 2 the entry lasts 19 cycles. After the two pushes it reads the new pc low byte from address {i_reg, ack_byte} and the high byte from that address plus one. Each read is a 3-cycle period with mem_re high.
- R10: In mode 0, an ack_byte of the form 11xxx111 (a restart opcode) gives a 13-cycle entry to address {10'b0, ack_byte[5:3], 3'b000}. An ack_byte of 0xCD gives a 19-cycle entry (13-cycle acknowledge) to call_addr.
- R11: In mode 0, any other ack_byte sets ack_err, which stays set until reset. The entry then ends after a 6-cycle acknowledge with no memory write and with pc and sp unchanged, although both enable flags are cleared.
- R12: Every entry increments r_reg[6:0] by one (wrapping modulo 128) and keeps r_reg[7].
- R13: tstates increases by one for each busy cycle. done is high for exactly one cycle, the last busy cycle of an entry.
- R14: Core writes take effect only while the block is idle. A write of mode value 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction-boundary strobe |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| int_req | input | 1 | Maskable request, level sensitive |
| ack_byte | input | 8 | Byte supplied by the interrupting device |
| call_addr | input | 16 | Call target used with the 0xCD acknowledge byte |
| mem_rdata | input | 8 | Read data from memory |
| pc_we | input | 1 | Core write of pc |
| pc_wd | input | 16 | pc write value |
| sp_we | input | 1 | Core write of sp |
| sp_wd | input | 16 | sp write value |
| i_we | input | 1 | Core write of the vector-base register |
| i_wd | input | 8 | Vector-base write value |
| r_we | input | 1 | Core write of the refresh counter |
| r_wd | input | 8 | Refresh counter write value |
| im_we | input | 1 | Core write of the interrupt mode |
| im_wd | input | 2 | Interrupt mode write value |
| iff_we | input | 1 | Core write of both enable flags |
| iff_wd | input | 1 | Enable flag write value |
| halt_set | input | 1 | Core entered the halted state |
| mem_addr | output | 16 | Memory address during pushes and vector reads |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe, last cycle of a push |
| mem_re | output | 1 | Read enable, whole vector read period |
| ack_cycle | output | 1 | High during the acknowledge period |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | Last cycle of an entry |
| ack_err | output | 1 | Sticky unsupported-acknowledge-byte flag |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| i_reg | output | 8 | Vector-base register |
| r_reg | output | 8 | Refresh counter |
| im | output | 2 | Interrupt mode |
| iff1 | output | 1 | Interrupt enable flag 1 |
| iff2 | output | 1 | Interrupt enable flag 2 |
| halted | output | 1 | Halted flag |
| nmi_pend | output | 1 | Latched non-maskable request |
| tstates | output | 32 | T-states spent in entry sequences |

## Verification
The assertions check local rules on every cycle. These are the edge latch, the pre-decrement of sp at each write strobe, the effect of each kind of entry start on the enable flags, the halted flag and the refresh counter, the absence of writes in a rejected mode-0 entry, the single-cycle done strobe and the legal mode register. Whole-sequence properties can only be shown by the bench's directed scenarios. These cover the exact entry length for each kind, the address and data order of the pushes, the vector table fetch, the choice of target, and the priority of the non-maskable request. They also cover the loss of a request that drops before the boundary and the rejection of core writes while busy.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ACK,
        PH_PUSH_HI,
        PH_PUSH_LO,
        PH_RD_LO,
        PH_RD_HI
    } phase_e;

    typedef enum logic [2:0] {
        EK_NONE,
        EK_NMI,
        EK_MODE1,
        EK_MODE2,
        EK_RESTART,
        EK_CALL,
        EK_BAD
    } entry_e;

    typedef struct packed {
        entry_e      kind;
        logic [15:0] target;
        logic [15:0] vec;
    } entry_t;

    localparam logic [7:0] OP_CALL = 8'hCD;

    function automatic logic is_restart(input logic [7:0] op);
        return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    endfunction

    function automatic logic [15:0] restart_target(input logic [7:0] op);
        return {10'd0, op[5:3], 3'b000};
    endfunction

    function automatic logic [7:0] refresh_step(input logic [7:0] r);
        return {r[7], r[6:0] + 7'd1};
    endfunction

endpackage

// File: rtl/intr_nmi_latch.sv
module intr_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi,
    input  logic take,
    output logic pend
);
    logic nmi_q;
    logic rise;

    assign rise = nmi & ~nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_q <= nmi;
            pend  <= (pend & ~take) | rise;
        end
    end

    AST_EDGE_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (nmi && !nmi_q) |=> pend); // R2

endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
    import intr_seq_pkg::*;
#(
    parameter logic [15:0] NMI_VEC   = 16'h0066,
    parameter logic [15:0] MODE1_VEC = 16'h0038
) (
    input  logic        boundary,
    input  logic        idle,
    input  logic        nmi_pend,
    input  logic        int_req,
    input  logic        iff1,
    input  logic [1:0]  im,
    input  logic [7:0]  ack_byte,
    input  logic [15:0] call_addr,
    input  logic [7:0]  i_reg,
    output logic        take_nmi,
    output logic        take_int,
    output entry_t      entry
);
    logic sample;

    assign sample   = boundary & idle;
    assign take_nmi = sample & nmi_pend;
    assign take_int = sample & ~nmi_pend & int_req & iff1;

    always_comb begin
        entry.kind   = EK_NONE;
        entry.target = 16'h0000;
        entry.vec    = {i_reg, ack_byte};
        if (take_nmi) begin
            entry.kind   = EK_NMI;
            entry.target = NMI_VEC;
        end else if (take_int) begin
            case (im)
                2'd0: begin
                    if (is_restart(ack_byte)) begin
                        entry.kind   = EK_RESTART;
                        entry.target = restart_target(ack_byte);
                    end else if (ack_byte == OP_CALL) begin
                        entry.kind   = EK_CALL;
                        entry.target = call_addr;
                    end else begin
                        entry.kind = EK_BAD;
                    end
                end
                2'd2:    entry.kind = EK_MODE2;
                default: begin
                    entry.kind   = EK_MODE1;
                    entry.target = MODE1_VEC;
                end
            endcase
        end
    end

endmodule

// File: rtl/intr_entry_fsm.sv
module intr_entry_fsm
    import intr_seq_pkg::*;
#(
    parameter int NMI_ACK_T  = 5,
    parameter int INT_ACK_T  = 7,
    parameter int CALL_ACK_T = 13,
    parameter int BAD_ACK_T  = 6,
    parameter int MEM_T      = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  entry_t      entry,
    input  logic [15:0] ret_pc,
    input  logic [15:0] sp,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        ack_cycle,
    output logic        done,
    output logic        pc_load,
    output logic [15:0] pc_new,
    output logic        err_pulse,
    output logic        sp_dec,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re
);
    localparam int MAX_A = (NMI_ACK_T > INT_ACK_T) ? NMI_ACK_T : INT_ACK_T;
    localparam int MAX_B = (CALL_ACK_T > BAD_ACK_T) ? CALL_ACK_T : BAD_ACK_T;
    localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_T = (MAX_C > MEM_T) ? MAX_C : MEM_T;
    localparam int TW    = $clog2(MAX_T + 1);

    localparam logic [TW-1:0] L_NMI  = TW'(NMI_ACK_T);
    localparam logic [TW-1:0] L_INT  = TW'(INT_ACK_T);
    localparam logic [TW-1:0] L_CALL = TW'(CALL_ACK_T);
    localparam logic [TW-1:0] L_BAD  = TW'(BAD_ACK_T);
    localparam logic [TW-1:0] L_MEM  = TW'(MEM_T);

    phase_e        phase, phase_nx;
    entry_e        kind_q;
    logic [15:0]   target_q;
    logic [15:0]   vec_q;
    logic [15:0]   ret_q;
    logic [7:0]    lo_q;
    logic [TW-1:0] tcnt;
    logic [TW-1:0] len;
    logic          last;

    function automatic logic [TW-1:0] ack_len(input entry_e k);
        case (k)
            EK_NMI:  return L_NMI;
            EK_CALL: return L_CALL;
            EK_BAD:  return L_BAD;
            default: return L_INT;
        endcase
    endfunction

    assign busy      = (phase != PH_IDLE);
    assign ack_cycle = (phase == PH_ACK);
    assign len       = (phase == PH_ACK) ? ack_len(kind_q) : L_MEM;
    assign last      = busy && (tcnt == len - TW'(1));

    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:    if (start) phase_nx = PH_ACK;
            PH_ACK:     if (last) phase_nx = (kind_q == EK_BAD) ? PH_IDLE : PH_PUSH_HI;
            PH_PUSH_HI: if (last) phase_nx = PH_PUSH_LO;
            PH_PUSH_LO: if (last) phase_nx = (kind_q == EK_MODE2) ? PH_RD_LO : PH_IDLE;
            PH_RD_LO:   if (last) phase_nx = PH_RD_HI;
            PH_RD_HI:   if (last) phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    assign done      = last && (phase_nx == PH_IDLE);
    assign pc_load   = done && (kind_q != EK_BAD);
    assign pc_new    = (phase == PH_RD_HI) ? {mem_rdata, lo_q} : target_q;
    assign err_pulse = done && (kind_q == EK_BAD);

    always_comb begin
        mem_addr  = 16'h0000;
        mem_wdata = 8'h00;
        case (phase)
            PH_PUSH_HI: begin
                mem_addr  = sp - 16'd1;
                mem_wdata = ret_q[15:8];
            end
            PH_PUSH_LO: begin
                mem_addr  = sp - 16'd1;
                mem_wdata = ret_q[7:0];
            end
            PH_RD_LO: mem_addr = vec_q;
            PH_RD_HI: mem_addr = vec_q + 16'd1;
            default: ;
        endcase
    end

    assign mem_we = last && ((phase == PH_PUSH_HI) || (phase == PH_PUSH_LO));
    assign mem_re = (phase == PH_RD_LO) || (phase == PH_RD_HI);
    assign sp_dec = mem_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            kind_q   <= EK_NONE;
            target_q <= 16'h0000;
            vec_q    <= 16'h0000;
            ret_q    <= 16'h0000;
            lo_q     <= 8'h00;
            tcnt     <= '0;
        end else begin
            phase <= phase_nx;
            if (phase == PH_IDLE) begin
                tcnt <= '0;
                if (start) begin
                    kind_q   <= entry.kind;
                    target_q <= entry.target;
                    vec_q    <= entry.vec;
                    ret_q    <= ret_pc;
                end
            end else if (last) begin
                tcnt <= '0;
            end else begin
                tcnt <= tcnt + TW'(1);
            end
            if (phase == PH_RD_LO && last) lo_q <= mem_rdata;
        end
    end

    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (busy && kind_q == EK_BAD) |-> !mem_we); // R11
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy); // R13
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R13
    AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R9

endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int          NMI_ACK_T  = 5,
    parameter int          INT_ACK_T  = 7,
    parameter int          CALL_ACK_T = 13,
    parameter int          BAD_ACK_T  = 6,
    parameter int          MEM_T      = 3,
    parameter int          CNT_W      = 32,
    parameter logic [15:0] NMI_VEC    = 16'h0066,
    parameter logic [15:0] MODE1_VEC  = 16'h0038
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  logic             nmi,
    input  logic             int_req,
    input  logic [7:0]       ack_byte,
    input  logic [15:0]      call_addr,
    input  logic [7:0]       mem_rdata,
    input  logic             pc_we,
    input  logic [15:0]      pc_wd,
    input  logic             sp_we,
    input  logic [15:0]      sp_wd,
    input  logic             i_we,
    input  logic [7:0]       i_wd,
    input  logic             r_we,
    input  logic [7:0]       r_wd,
    input  logic             im_we,
    input  logic [1:0]       im_wd,
    input  logic             iff_we,
    input  logic             iff_wd,
    input  logic             halt_set,
    output logic [15:0]      mem_addr,
    output logic [7:0]       mem_wdata,
    output logic             mem_we,
    output logic             mem_re,
    output logic             ack_cycle,
    output logic             busy,
    output logic             done,
    output logic             ack_err,
    output logic [15:0]      pc,
    output logic [15:0]      sp,
    output logic [7:0]       i_reg,
    output logic [7:0]       r_reg,
    output logic [1:0]       im,
    output logic             iff1,
    output logic             iff2,
    output logic             halted,
    output logic             nmi_pend,
    output logic [CNT_W-1:0] tstates
);
    logic        take_nmi;
    logic        take_int;
    logic        start;
    entry_t      entry;
    logic [15:0] ret_pc;
    logic        pc_load;
    logic [15:0] pc_new;
    logic        err_pulse;
    logic        sp_dec;

    assign start  = take_nmi | take_int;
    assign ret_pc = halted ? pc + 16'd1 : pc;

    intr_nmi_latch u_nmi (
        .clk  (clk),
        .rst  (rst),
        .nmi  (nmi),
        .take (take_nmi),
        .pend (nmi_pend)
    );

    intr_arbiter #(
        .NMI_VEC   (NMI_VEC),
        .MODE1_VEC (MODE1_VEC)
    ) u_arb (
        .boundary  (boundary),
        .idle      (~busy),
        .nmi_pend  (nmi_pend),
        .int_req   (int_req),
        .iff1      (iff1),
        .im        (im),
        .ack_byte  (ack_byte),
        .call_addr (call_addr),
        .i_reg     (i_reg),
        .take_nmi  (take_nmi),
        .take_int  (take_int),
        .entry     (entry)
    );

    intr_entry_fsm #(
        .NMI_ACK_T  (NMI_ACK_T),
        .INT_ACK_T  (INT_ACK_T),
        .CALL_ACK_T (CALL_ACK_T),
        .BAD_ACK_T  (BAD_ACK_T),
        .MEM_T      (MEM_T)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .entry     (entry),
        .ret_pc    (ret_pc),
        .sp        (sp),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .ack_cycle (ack_cycle),
        .done      (done),
        .pc_load   (pc_load),
        .pc_new    (pc_new),
        .err_pulse (err_pulse),
        .sp_dec    (sp_dec),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc      <= 16'h0000;
            sp      <= 16'h0000;
            i_reg   <= 8'h00;
            r_reg   <= 8'h00;
            im      <= 2'd0;
            iff1    <= 1'b0;
            iff2    <= 1'b0;
            halted  <= 1'b0;
            ack_err <= 1'b0;
            tstates <= '0;
        end else begin
            if (start) begin
                iff1   <= 1'b0;
                if (take_int) iff2 <= 1'b0;
                halted <= 1'b0;
                pc     <= ret_pc;
                r_reg  <= refresh_step(r_reg);
            end else if (!busy) begin
                if (pc_we)  pc    <= pc_wd;
                if (sp_we)  sp    <= sp_wd;
                if (i_we)   i_reg <= i_wd;
                if (r_we)   r_reg <= r_wd;
                if (im_we && im_wd != 2'd3) im <= im_wd;
                if (iff_we) begin
                    iff1 <= iff_wd;
                    iff2 <= iff_wd;
                end
                if (halt_set) halted <= 1'b1;
            end
            if (sp_dec)    sp      <= sp - 16'd1;
            if (pc_load)   pc      <= pc_new;
            if (err_pulse) ack_err <= 1'b1;
            if (busy)      tstates <= tstates + CNT_W'(1);
        end
    end

    AST_NMI_KEEPS_IFF2: assert property (@(posedge clk) disable iff (rst)
        take_nmi |=> (!iff1 && iff2 == $past(iff2))); // R3
    AST_SP_PREDEC: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - 16'd1)); // R3
    AST_INT_CLEARS_IFF: assert property (@(posedge clk) disable iff (rst)
        take_int |=> (!iff1 && !iff2)); // R6
    AST_HALT_EXIT: assert property (@(posedge clk) disable iff (rst)
        start |=> !halted); // R7
    AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (rst)
        start |=> (r_reg[6:0] == $past(r_reg[6:0]) + 7'd1 && r_reg[7] == $past(r_reg[7]))); // R12
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        im != 2'd3); // R14

endmodule

// File: tb/intr_entry_seq_tb.sv
`timescale 1ns/1ps
module intr_entry_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boundary = 1'b0, nmi = 1'b0, int_req = 1'b0;
    logic [7:0]  ack_byte = 8'h00;
    logic [15:0] call_addr = 16'h0000;
    logic [7:0]  mem_rdata;
    logic        pc_we = 1'b0, sp_we = 1'b0, i_we = 1'b0, r_we = 1'b0;
    logic        im_we = 1'b0, iff_we = 1'b0, iff_wd = 1'b0, halt_set = 1'b0;
    logic [15:0] pc_wd = 16'h0, sp_wd = 16'h0;
    logic [7:0]  i_wd = 8'h0, r_wd = 8'h0;
    logic [1:0]  im_wd = 2'd0;
    logic [15:0] mem_addr, pc, sp;
    logic [7:0]  mem_wdata, i_reg, r_reg;
    logic        mem_we, mem_re, ack_cycle, busy, done, ack_err;
    logic [1:0]  im;
    logic        iff1, iff2, halted, nmi_pend;
    logic [31:0] tstates;

    int errors = 0;
    int checks = 0;
    logic [15:0] wa [0:3];
    logic [7:0]  wd [0:3];
    int nw = 0;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction
    assign mem_rdata = memf(mem_addr);

    always @(negedge clk) begin
        if (mem_we) begin
            if (nw < 4) begin
                wa[nw] = mem_addr;
                wd[nw] = mem_wdata;
            end
            nw = nw + 1;
        end
    end

    intr_entry_seq u_dut (
        .clk(clk), .rst(rst), .boundary(boundary), .nmi(nmi), .int_req(int_req),
        .ack_byte(ack_byte), .call_addr(call_addr), .mem_rdata(mem_rdata),
        .pc_we(pc_we), .pc_wd(pc_wd), .sp_we(sp_we), .sp_wd(sp_wd),
        .i_we(i_we), .i_wd(i_wd), .r_we(r_we), .r_wd(r_wd),
        .im_we(im_we), .im_wd(im_wd), .iff_we(iff_we), .iff_wd(iff_wd),
        .halt_set(halt_set), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .ack_cycle(ack_cycle), .busy(busy),
        .done(done), .ack_err(ack_err), .pc(pc), .sp(sp), .i_reg(i_reg),
        .r_reg(r_reg), .im(im), .iff1(iff1), .iff2(iff2), .halted(halted),
        .nmi_pend(nmi_pend), .tstates(tstates)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [15:0] p, input logic [15:0] s, input logic [1:0] m,
                         input logic en);
        @(negedge clk);
        pc_we = 1; pc_wd = p; sp_we = 1; sp_wd = s;
        im_we = 1; im_wd = m; iff_we = 1; iff_wd = en;
        @(negedge clk);
        pc_we = 0; sp_we = 0; im_we = 0; iff_we = 0;
    endtask

    task automatic run_entry(output int n, output int nd);
        nw = 0; n = 0; nd = 0;
        @(negedge clk); boundary = 1;
        @(negedge clk); boundary = 0;
        for (int k = 0; k < 40; k++) begin
            if (!busy) break;
            n++;
            if (done) nd++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_nmi();
        @(negedge clk); nmi = 1;
        @(negedge clk); nmi = 0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 pc", pc, 0);  chk("R1 sp", sp, 0);
        chk("R1 i", i_reg, 0); chk("R1 r", r_reg, 0);
        chk("R1 im", im, 0);
        chk("R1 flags", {iff1, iff2, halted, nmi_pend, ack_err, busy}, 0);
        chk("R1 tstates", tstates, 0);
    endtask

    task automatic t_nmi();
        int n, nd;
        logic [31:0] t0;
        setup(16'h1234, 16'h8000, 2'd1, 1'b1);
        @(negedge clk); nmi = 1;
        repeat (3) @(negedge clk);
        chk("R2 pending set", nmi_pend, 1);
        t0 = tstates;
        run_entry(n, nd);
        chk("R3 nmi length", n, 11);
        chk("R13 done once", nd, 1);
        chk("R13 tstates", tstates - t0, 11);
        chk("R3 pc vector", pc, 16'h0066);
        chk("R3 sp", sp, 16'h7FFE);
        chk("R3 writes", nw, 2);
        chk("R3 push hi", {wa[0], wd[0]}, {16'h7FFF, 8'h12});
        chk("R3 push lo", {wa[1], wd[1]}, {16'h7FFE, 8'h34});
        chk("R3 iff1/iff2", {iff1, iff2}, 2'b01);
        chk("R2 pending cleared", nmi_pend, 0);
        run_entry(n, nd);
        chk("R2 held level no retrigger", n, 0);
        nmi = 0;
    endtask

    task automatic t_priority();
        int n, nd;
        setup(16'h0100, 16'h6000, 2'd1, 1'b1);
        int_req = 1;
        pulse_nmi();
        run_entry(n, nd);
        chk("R4 nmi wins", {16'(n), pc}, {16'd11, 16'h0066});
        chk("R4 iff2 kept", iff2, 1);
        run_entry(n, nd);
        chk("R5 iff1 clear blocks int", n, 0);
        @(negedge clk); iff_we = 1; iff_wd = 1;
        @(negedge clk); iff_we = 0;
        run_entry(n, nd);
        chk("R8 mode1 length", n, 13);
        chk("R8 mode1 target", pc, 16'h0038);
        chk("R6 flags cleared", {iff1, iff2}, 2'b00);
        int_req = 0;
    endtask

    task automatic t_lost();
        int n, nd;
        setup(16'h0200, 16'h6000, 2'd1, 1'b1);
        int_req = 1;
        repeat (5) @(negedge clk);
        chk("R5 no boundary no entry", busy, 0);
        int_req = 0;
        run_entry(n, nd);
        chk("R5 dropped request lost", {16'(n), pc}, {16'd0, 16'h0200});
    endtask

    task automatic t_halt();
        int n, nd;
        setup(16'h2000, 16'h9000, 2'd1, 1'b1);
        @(negedge clk); halt_set = 1;
        @(negedge clk); halt_set = 0;
        chk("R7 halted set", halted, 1);
        int_req = 1;
        run_entry(n, nd);
        int_req = 0;
        chk("R7 halted cleared", halted, 0);
        chk("R7 pushed pc+1", {wd[0], wd[1]}, 16'h2001);
    endtask

    task automatic t_mode2();
        int n, nd;
        setup(16'h4567, 16'hA000, 2'd2, 1'b1);
        @(negedge clk); i_we = 1; i_wd = 8'h3A;
        @(negedge clk); i_we = 0;
        ack_byte = 8'h7C; int_req = 1;
        run_entry(n, nd);
        int_req = 0;
        chk("R9 mode2 length", n, 19);
        chk("R9 pushes", {wa[0], wd[0], wa[1], wd[1]}, {16'h9FFF, 8'h45, 16'h9FFE, 8'h67});
        chk("R9 table pc", pc, {memf(16'h3A7D), memf(16'h3A7C)});
        chk("R9 sp", sp, 16'h9FFE);
    endtask

    task automatic t_mode0();
        int n, nd;
        setup(16'h1000, 16'hC000, 2'd0, 1'b1);
        ack_byte = 8'hEF; int_req = 1;
        run_entry(n, nd);
        chk("R10 restart length", n, 13);
        chk("R10 restart target", pc, 16'h0028);
        setup(16'h1357, 16'hC000, 2'd0, 1'b1);
        ack_byte = 8'hCD; call_addr = 16'hBEEF;
        run_entry(n, nd);
        chk("R10 call length", n, 19);
        chk("R10 call target", pc, 16'hBEEF);
        chk("R10 call push", {wd[0], wd[1]}, 16'h1357);
        int_req = 0;
    endtask

    task automatic t_bad();
        int n, nd;
        logic [31:0] t0;
        setup(16'h1111, 16'h5000, 2'd0, 1'b1);
        ack_byte = 8'h00; int_req = 1;
        t0 = tstates;
        run_entry(n, nd);
        int_req = 0;
        chk("R11 length", n, 6);
        chk("R11 no writes", nw, 0);
        chk("R11 pc sp kept", {pc, sp}, {16'h1111, 16'h5000});
        chk("R11 err and flags", {ack_err, iff1, iff2}, 3'b100);
        chk("R13 tstates bad", tstates - t0, 6);
        repeat (3) @(negedge clk);
        chk("R11 err sticky", ack_err, 1);
    endtask

    task automatic t_refresh();
        int n, nd;
        setup(16'h0300, 16'h6000, 2'd1, 1'b1);
        @(negedge clk); r_we = 1; r_wd = 8'h7F;
        @(negedge clk); r_we = 0;
        int_req = 1;
        run_entry(n, nd);
        chk("R12 wrap low", r_reg, 8'h00);
        setup(16'h0300, 16'h6000, 2'd1, 1'b1);
        @(negedge clk); r_we = 1; r_wd = 8'hFF;
        @(negedge clk); r_we = 0;
        run_entry(n, nd);
        chk("R12 keep bit7", r_reg, 8'h80);
        int_req = 0;
    endtask

    task automatic t_writes();
        setup(16'h0400, 16'h6000, 2'd2, 1'b1);
        @(negedge clk); im_we = 1; im_wd = 2'd3;
        @(negedge clk); im_we = 0;
        chk("R14 mode 3 ignored", im, 2);
        @(negedge clk); i_we = 1; i_wd = 8'h20;
        @(negedge clk); i_we = 0;
        setup(16'h0400, 16'h6000, 2'd1, 1'b1);
        int_req = 1;
        @(negedge clk); boundary = 1;
        @(negedge clk); boundary = 0; int_req = 0;
        @(negedge clk); i_we = 1; i_wd = 8'h55;
        @(negedge clk); i_we = 0;
        for (int k = 0; k < 40; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        chk("R14 busy write ignored", i_reg, 8'h20);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_nmi();
        t_priority();
        t_lost();
        t_halt();
        t_mode2();
        t_mode0();
        t_bad();
        t_refresh();
        t_writes();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule